// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

The controller sits beside a small 16-bit microcontroller core and decides which pending exception or interrupt is serviced next. It takes reset-class events (a clock monitor failure and a watchdog failure), an unimplemented-opcode trap, a software interrupt, a non-maskable-style pin whose mask can only be cleared by software, a maskable interrupt pin and a bank of peripheral request lines. It raises one registered request to the core together with the 16-bit vector address of the winning source. That pair holds steady until the core acknowledges it.

The block also keeps the two mask bits of the core's condition code register. One bit masks the special pin. The other masks the maskable pin and every peripheral source. A small register interface holds two registers. The promotion register lifts one chosen peripheral to the top of the maskable group. The pin control register selects edge or level sensing for the maskable pin, gates that pin on or off, and stores a stop-exit delay option for the clock logic.

Top module: `irq_vector_arbiter`

## Requirements
- R1: While reset is asserted, int_req_o is 0, both masks read 1, hprio_rd_o reads 8'hF2 and ctrl_rd_o reads 8'h40. The first request after reset carries vector 16'hFFFE, and that request is withdrawn once it is acknowledged.
- R2: The unmaskable sources win in this fixed order, highest first: pending reset FFFE, clock monitor FFFC, watchdog FFFA, opcode trap FFF8, software interrupt FFF6. Next come the special pin (FFF4, active low), the maskable pin (FFF2, active low) and then the peripherals.
- R3: Peripheral k (k = 0 .. NUM_PERIPH-1) uses vector 16'hFFF0 - 2k. With no promotion in effect, a lower k wins, which means the higher vector wins.
- R4: While I = 1, the maskable pin and all peripherals are not serviced. While X = 1, only the special pin is not serviced.
- R5: A CCR write (ccr_wdata_i[1] = X, ccr_wdata_i[0] = I) sets I to the written value. It can clear X, but a written 1 never sets X.
- R6: Acknowledging the maskable pin or a peripheral sets I. Acknowledging the special pin (FFF4) sets both X and I.
- R7: A write with reg_sel_i = 0 stores reg_wdata_i[7:1] into the promotion register, and bit 0 reads back 0. A pending peripheral whose vector low byte equals the register wins over the maskable pin and over the other peripherals. A value that matches no peripheral leaves the default order.
- R8: A promotion register write made while I = 0 is ignored.
- R9: The control register (reg_sel_i = 1) has these fields: bit 7 = edge select, bit 6 = pin enable, bit 5 = stop delay. In level mode (bit 7 = 0), a low pin requests. In edge mode, a falling edge latches a pending flag that only the acknowledgement of FFF2 clears, so a pin held low does not request again.
- R10: With bit 6 = 0 the maskable pin never requests. Bits 4:0 of ctrl_rd_o always read 0.
- R11: int_req_o and vec_o are registered. Once raised, they hold their value until the cycle after ack_i is seen high. A new request can be raised only on a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cm_fail_i | input | 1 | Clock monitor failure event |
| wdog_fail_i | input | 1 | Watchdog failure event |
| trap_i | input | 1 | Unimplemented opcode trap |
| swi_i | input | 1 | Software interrupt |
| xirq_ni | input | 1 | Special interrupt pin, active low |
| irq_ni | input | 1 | Maskable interrupt pin, active low |
| periph_req_i | input | NUM_PERIPH | Peripheral request lines |
| ccr_wr_i | input | 1 | CCR mask write strobe |
| ccr_wdata_i | input | 2 | Mask write data, bit 1 = X, bit 0 = I |
| x_mask_o | output | 1 | X mask bit |
| i_mask_o | output | 1 | I mask bit |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = promotion register, 1 = control register |
| reg_wdata_i | input | 8 | Register write data |
| hprio_rd_o | output | 8 | Promotion register readback |
| ctrl_rd_o | output | 8 | Control register readback |
| int_req_o | output | 1 | Request to the core |
| vec_o | output | 16 | Vector address of the granted source |
| ack_i | input | 1 | Acknowledge from the core |

## Verification
Level-sensed and unmaskable inputs produce a request on the first rising edge after they are applied. An edge on the maskable pin needs two edges: one to latch the pending flag and one to register the request. Mask, promotion and control updates are visible one edge after their write or acknowledge. The bench drives on falling edges and samples on the falling edge that follows the edge at which each result is due. The edge-mode case also checks that the request is still low one edge early. The stability case holds a grant for several cycles while a higher source arrives.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   localparam logic [15:0] VEC_RESET = 16'hFFFE;
   localparam logic [15:0] VEC_CMON  = 16'hFFFC;
   localparam logic [15:0] VEC_WDOG  = 16'hFFFA;
   localparam logic [15:0] VEC_TRAP  = 16'hFFF8;
   localparam logic [15:0] VEC_SWI   = 16'hFFF6;
   localparam logic [15:0] VEC_XPIN  = 16'hFFF4;
   localparam logic [15:0] VEC_IPIN  = 16'hFFF2;
   localparam logic [15:0] VEC_PTOP  = 16'hFFF0;
   localparam logic [7:0]  HPRIO_RST = 8'hF2;
   localparam int          MAX_PERIPH = 120;

   typedef struct packed {
      logic edge_sel;
      logic pin_en;
      logic stop_dly;
   } pin_ctrl_t;

   function automatic logic [15:0] periph_vec(input int idx);
      return VEC_PTOP - 16'(2 * idx);
   endfunction
endpackage

// File: rtl/ivc_mask_regs.sv
module ivc_mask_regs
   import ivc_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      ccr_wr_i,
   input  logic [1:0] ccr_wdata_i,
   input  logic      reg_wr_i,
   input  logic      reg_sel_i,
   input  logic [7:0] reg_wdata_i,
   input  logic      hw_set_i_i,
   input  logic      hw_set_x_i,
   output logic      x_mask_o,
   output logic      i_mask_o,
   output logic [7:0] hprio_o,
   output pin_ctrl_t ctrl_o
);
   logic [6:0] hprio_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         x_mask_o <= 1'b1;
         i_mask_o <= 1'b1;
         hprio_q  <= HPRIO_RST[7:1];
         ctrl_o   <= '{edge_sel: 1'b0, pin_en: 1'b1, stop_dly: 1'b0};
      end else begin
         x_mask_o <= (x_mask_o & (ccr_wr_i ? ccr_wdata_i[1] : 1'b1)) | hw_set_x_i;
         i_mask_o <= (ccr_wr_i ? ccr_wdata_i[0] : i_mask_o) | hw_set_i_i;
         if (reg_wr_i && !reg_sel_i && i_mask_o)
            hprio_q <= reg_wdata_i[7:1];
         if (reg_wr_i && reg_sel_i)
            ctrl_o <= '{edge_sel: reg_wdata_i[7], pin_en: reg_wdata_i[6],
                        stop_dly: reg_wdata_i[5]};
      end
   end

   assign hprio_o = {hprio_q, 1'b0};
endmodule

// File: rtl/ivc_irq_sense.sv
module ivc_irq_sense (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_ni,
   input  logic edge_sel_i,
   input  logic clr_i,
   output logic active_o
);
   logic pin_q;
   logic pend_q;
   logic fall;

   assign fall = pin_q & ~pin_ni;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pin_q  <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         pin_q  <= pin_ni;
         pend_q <= edge_sel_i ? ((pend_q & ~clr_i) | fall) : 1'b0;
      end
   end

   assign active_o = edge_sel_i ? pend_q : ~pin_ni;
endmodule

// File: rtl/ivc_periph_pick.sv
module ivc_periph_pick
   import ivc_pkg::*;
#(
   parameter int NUM_PERIPH = 8,
   parameter bit PROMO_EN   = 1'b1
) (
   input  logic [NUM_PERIPH-1:0] req_i,
   input  logic [7:0]            hprio_i,
   output logic                  any_o,
   output logic [15:0]           win_vec_o,
   output logic                  promo_hit_o,
   output logic [15:0]           promo_vec_o
);
   logic [NUM_PERIPH-1:0] match;

   for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_match
      localparam logic [15:0] PV = periph_vec(g);
      if (PROMO_EN) begin : g_on
         assign match[g] = (PV[7:0] == hprio_i);
      end else begin : g_off
         assign match[g] = 1'b0;
      end
   end

   always_comb begin
      any_o     = 1'b0;
      win_vec_o = '0;
      for (int k = NUM_PERIPH - 1; k >= 0; k--) begin
         if (req_i[k]) begin
            any_o     = 1'b1;
            win_vec_o = periph_vec(k);
         end
      end
   end

   assign promo_hit_o = |(req_i & match);
   assign promo_vec_o = {8'hFF, hprio_i};
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
   import ivc_pkg::*;
#(
   parameter int NUM_PERIPH = 8,
   parameter bit PROMO_EN   = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  cm_fail_i,
   input  logic                  wdog_fail_i,
   input  logic                  trap_i,
   input  logic                  swi_i,
   input  logic                  xirq_ni,
   input  logic                  irq_ni,
   input  logic [NUM_PERIPH-1:0] periph_req_i,
   input  logic                  ccr_wr_i,
   input  logic [1:0]            ccr_wdata_i,
   output logic                  x_mask_o,
   output logic                  i_mask_o,
   input  logic                  reg_wr_i,
   input  logic                  reg_sel_i,
   input  logic [7:0]            reg_wdata_i,
   output logic [7:0]            hprio_rd_o,
   output logic [7:0]            ctrl_rd_o,
   output logic                  int_req_o,
   output logic [15:0]           vec_o,
   input  logic                  ack_i
);
   if (NUM_PERIPH < 1 || NUM_PERIPH > MAX_PERIPH) begin : g_bad_count
      $error("NUM_PERIPH must lie in 1..%0d", MAX_PERIPH);
   end

   pin_ctrl_t   ctrl;
   logic        ack_fire, hw_set_i, hw_set_x, pin_clr, pin_act;
   logic        rst_pend_q;
   logic        p_any, p_promo;
   logic [15:0] p_vec, p_promo_vec;
   logic        win_valid;
   logic [15:0] win_vec;

   assign ack_fire = int_req_o & ack_i;
   assign hw_set_x = ack_fire & (vec_o == VEC_XPIN);
   assign hw_set_i = ack_fire & (vec_o <= VEC_XPIN);
   assign pin_clr  = ack_fire & (vec_o == VEC_IPIN);

   ivc_mask_regs u_regs (
      .clk_i, .rst_ni, .ccr_wr_i, .ccr_wdata_i, .reg_wr_i, .reg_sel_i,
      .reg_wdata_i, .hw_set_i_i(hw_set_i), .hw_set_x_i(hw_set_x),
      .x_mask_o, .i_mask_o, .hprio_o(hprio_rd_o), .ctrl_o(ctrl)
   );

   ivc_irq_sense u_sense (
      .clk_i, .rst_ni, .pin_ni(irq_ni), .edge_sel_i(ctrl.edge_sel),
      .clr_i(pin_clr), .active_o(pin_act)
   );

   ivc_periph_pick #(.NUM_PERIPH(NUM_PERIPH), .PROMO_EN(PROMO_EN)) u_pick (
      .req_i(periph_req_i), .hprio_i(hprio_rd_o), .any_o(p_any),
      .win_vec_o(p_vec), .promo_hit_o(p_promo), .promo_vec_o(p_promo_vec)
   );

   assign ctrl_rd_o = {ctrl.edge_sel, ctrl.pin_en, ctrl.stop_dly, 5'b0};

   always_comb begin
      win_valid = 1'b1;
      win_vec   = '0;
      if (rst_pend_q)                       win_vec = VEC_RESET;
      else if (cm_fail_i)                   win_vec = VEC_CMON;
      else if (wdog_fail_i)                 win_vec = VEC_WDOG;
      else if (trap_i)                      win_vec = VEC_TRAP;
      else if (swi_i)                       win_vec = VEC_SWI;
      else if (!xirq_ni && !x_mask_o)       win_vec = VEC_XPIN;
      else if (!i_mask_o && p_promo)        win_vec = p_promo_vec;
      else if (!i_mask_o && pin_act && ctrl.pin_en) win_vec = VEC_IPIN;
      else if (!i_mask_o && p_any)          win_vec = p_vec;
      else                                  win_valid = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         int_req_o  <= 1'b0;
         vec_o      <= '0;
         rst_pend_q <= 1'b1;
      end else if (int_req_o) begin
         if (ack_i) begin
            int_req_o <= 1'b0;
            if (vec_o == VEC_RESET) rst_pend_q <= 1'b0;
         end
      end else if (win_valid) begin
         int_req_o <= 1'b1;
         vec_o     <= win_vec;
      end
   end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        int_req_o,
   input logic        ack_i,
   input logic [15:0] vec_o,
   input logic        x_mask_o,
   input logic        i_mask_o,
   input logic [7:0]  hprio_rd_o
);
   assert_vec_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int_req_o && !ack_i) |=> (int_req_o && $stable(vec_o)));

   assert_req_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int_req_o && ack_i) |=> !int_req_o);

   assert_masked_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(int_req_o) && $past(i_mask_o)) |-> (vec_o >= 16'hFFF4));

   assert_x_no_sw_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!x_mask_o && !(int_req_o && ack_i && vec_o == 16'hFFF4)) |=> !x_mask_o);

   assert_ack_sets_i_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int_req_o && ack_i && vec_o <= 16'hFFF4) |=> i_mask_o);

   assert_hprio_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !i_mask_o |=> $stable(hprio_rd_o));
endmodule

bind irq_vector_arbiter ivc_checker u_ivc_checker (
   .clk_i(clk_i), .rst_ni(rst_ni), .int_req_o(int_req_o), .ack_i(ack_i),
   .vec_o(vec_o), .x_mask_o(x_mask_o), .i_mask_o(i_mask_o), .hprio_rd_o(hprio_rd_o)
);

// File: tb/irq_vector_arbiter_bench.sv
`timescale 1ns/1ps
module irq_vector_arbiter_bench;
   localparam int NP = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cm = 0, wd = 0, trap = 0, swi = 0, xirq_n = 1, irq_n = 1;
   logic [NP-1:0] periph = '0;
   logic ccr_wr = 0, reg_wr = 0, reg_sel = 0, ack = 0;
   logic [1:0] ccr_wdata = '0;
   logic [7:0] reg_wdata = '0;
   logic x_mask, i_mask, int_req;
   logic [7:0] hprio_rd, ctrl_rd;
   logic [15:0] vec;

   int n_chk = 0, n_bad = 0;
   logic m_x = 1, m_i = 1;
   logic [7:0] m_hprio = 8'hF2, m_ctrl = 8'h40;

   always #2.5 clk = ~clk;

   irq_vector_arbiter #(.NUM_PERIPH(NP)) u_irq_vector_arbiter (
      .clk_i(clk), .rst_ni(rst_n), .cm_fail_i(cm), .wdog_fail_i(wd), .trap_i(trap),
      .swi_i(swi), .xirq_ni(xirq_n), .irq_ni(irq_n), .periph_req_i(periph),
      .ccr_wr_i(ccr_wr), .ccr_wdata_i(ccr_wdata), .x_mask_o(x_mask), .i_mask_o(i_mask),
      .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
      .hprio_rd_o(hprio_rd), .ctrl_rd_o(ctrl_rd), .int_req_o(int_req), .vec_o(vec),
      .ack_i(ack)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Expected winner {valid, vector}, level sensing assumed
   function automatic logic [16:0] model(input logic c, w, t, s, xn, in_n,
                                         input logic [NP-1:0] p);
      logic [16:0] best = '0;
      if (c) return {1'b1, 16'hFFFC};
      if (w) return {1'b1, 16'hFFFA};
      if (t) return {1'b1, 16'hFFF8};
      if (s) return {1'b1, 16'hFFF6};
      if (!xn && !m_x) return {1'b1, 16'hFFF4};
      if (m_i) return '0;
      for (int k = 0; k < NP; k++)
         if (p[k] && (8'hF0 - 8'(2 * k)) == m_hprio) return {1'b1, 16'hFFF0 - 16'(2 * k)};
      if (!in_n && m_ctrl[6]) return {1'b1, 16'hFFF2};
      for (int k = NP - 1; k >= 0; k--)
         if (p[k]) best = {1'b1, 16'hFFF0 - 16'(2 * k)};
      return best;
   endfunction

   task automatic clear_inputs();
      cm = 0; wd = 0; trap = 0; swi = 0; xirq_n = 1; irq_n = 1; periph = '0;
   endtask

   task automatic do_ack(input string tag);
      logic [15:0] v;
      v = vec;
      ack = 1;
      @(posedge clk); @(negedge clk);
      ack = 0;
      if (v == 16'hFFF4) begin m_x = 1; m_i = 1; end
      else if (v <= 16'hFFF2) m_i = 1;
      chk({tag, " R11 req drops after ack"}, {31'b0, int_req}, 32'd0);
      chk({tag, " R6 X after ack"}, {31'b0, x_mask}, {31'b0, m_x});
      chk({tag, " R6 I after ack"}, {31'b0, i_mask}, {31'b0, m_i});
   endtask

   task automatic run_case(input string tag, input logic c, w, t, s, xn, in_n,
                           input logic [NP-1:0] p);
      logic [16:0] e;
      @(negedge clk);
      cm = c; wd = w; trap = t; swi = s; xirq_n = xn; irq_n = in_n; periph = p;
      e = model(c, w, t, s, xn, in_n, p);
      @(posedge clk); @(negedge clk);
      chk({tag, " request"}, {31'b0, int_req}, {31'b0, e[16]});
      if (e[16]) chk({tag, " vector"}, {16'b0, vec}, {16'b0, e[15:0]});
      if (int_req) do_ack(tag);
      clear_inputs();
      @(posedge clk);
   endtask

   task automatic ccr_write(input logic wx, input logic wi);
      @(negedge clk);
      ccr_wr = 1; ccr_wdata = {wx, wi};
      @(posedge clk); @(negedge clk);
      ccr_wr = 0;
      m_x = m_x & wx; m_i = wi;
      chk("R5 X after CCR write", {31'b0, x_mask}, {31'b0, m_x});
      chk("R5 I after CCR write", {31'b0, i_mask}, {31'b0, m_i});
   endtask

   task automatic reg_write(input logic sel, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1; reg_sel = sel; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 0;
      if (!sel && m_i) m_hprio = {d[7:1], 1'b0};
      if (sel) m_ctrl = d & 8'hE0;
      chk("R7 R8 promotion readback", {24'b0, hprio_rd}, {24'b0, m_hprio});
      chk("R10 control readback", {24'b0, ctrl_rd}, {24'b0, m_ctrl});
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int seed;
      seed = $urandom(32'h1F2E3D4C);
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 request in reset", {31'b0, int_req}, 32'd0);
      chk("R1 X in reset", {31'b0, x_mask}, 32'd1);
      chk("R1 I in reset", {31'b0, i_mask}, 32'd1);
      chk("R1 promotion in reset", {24'b0, hprio_rd}, 32'h0F2);
      chk("R1 control in reset", {24'b0, ctrl_rd}, 32'h040);
      rst_n = 1;
      @(posedge clk); @(negedge clk);
      chk("R1 reset request", {31'b0, int_req}, 32'd1);
      chk("R1 reset vector", {16'b0, vec}, 32'h0FFFE);
      do_ack("R1");
      @(posedge clk); @(negedge clk);
      chk("R1 reset not repeated", {31'b0, int_req}, 32'd0);

      // R2 fixed order, R4 masks
      run_case("R2 cm over all", 1, 1, 1, 1, 0, 0, '1);
      run_case("R2 wdog", 0, 1, 1, 1, 0, 0, '1);
      run_case("R2 trap", 0, 0, 1, 1, 0, 0, '1);
      run_case("R2 swi", 0, 0, 0, 1, 0, 0, '1);
      run_case("R4 X masks special pin", 0, 0, 0, 0, 0, 1, '0);
      // R5 X only clears
      ccr_write(1'b0, 1'b1);
      ccr_write(1'b1, 1'b1);
      chk("R5 X stays clear", {31'b0, x_mask}, 32'd0);
      run_case("R2 special pin over pin", 0, 0, 0, 0, 0, 0, '1);
      chk("R6 special ack sets X", {31'b0, x_mask}, 32'd1);
      run_case("R4 I masks pin and periph", 0, 0, 0, 0, 1, 0, '1);
      ccr_write(1'b0, 1'b0);
      run_case("R2 pin over periph", 0, 0, 0, 0, 1, 0, '1);
      ccr_write(1'b0, 1'b0);
      run_case("R3 default periph order", 0, 0, 0, 0, 1, 1, 8'b1010_0100);
      // R7 promotion
      reg_write(1'b0, 8'hEA);
      ccr_write(1'b0, 1'b0);
      run_case("R7 promoted periph over pin", 0, 0, 0, 0, 1, 0, 8'b0000_1001);
      reg_write(1'b0, 8'h55);
      chk("R7 bit0 reads zero", {24'b0, hprio_rd}, 32'h054);
      ccr_write(1'b0, 1'b0);
      run_case("R7 nonmatching keeps order", 0, 0, 0, 0, 1, 1, 8'b0000_0110);
      // R8 locked while I clear
      ccr_write(1'b0, 1'b0);
      reg_write(1'b0, 8'hF0);
      chk("R8 write ignored", {24'b0, hprio_rd}, 32'h054);

      // R9 edge mode
      reg_write(1'b1, 8'hC0);
      @(negedge clk); irq_n = 0;
      @(posedge clk); @(negedge clk); irq_n = 1;
      chk("R9 edge needs two edges", {31'b0, int_req}, 32'd0);
      @(posedge clk); @(negedge clk);
      chk("R9 edge request", {31'b0, int_req}, 32'd1);
      chk("R9 edge vector", {16'b0, vec}, 32'h0FFF2);
      do_ack("R9");
      ccr_write(1'b0, 1'b0);
      @(negedge clk); irq_n = 0;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      chk("R9 flag set by edge while clearing", {31'b0, int_req}, 32'd1);
      do_ack("R9 second");
      ccr_write(1'b0, 1'b0);
      repeat (3) @(negedge clk);
      chk("R9 held low no new request", {31'b0, int_req}, 32'd0);
      irq_n = 1;
      // R10 pin enable and low bits
      reg_write(1'b1, 8'h00);
      run_case("R10 disabled pin ignored", 0, 0, 0, 0, 1, 0, '0);
      reg_write(1'b1, 8'hFF);
      chk("R10 low bits zero", {24'b0, ctrl_rd}, 32'h0E0);
      reg_write(1'b1, 8'h40);

      // R11 stability under a higher arrival
      @(negedge clk); periph = 8'h01;
      @(posedge clk); @(negedge clk);
      chk("R11 grant raised", {16'b0, vec}, 32'h0FFF0);
      cm = 1;
      repeat (3) @(negedge clk);
      chk("R11 request held", {31'b0, int_req}, 32'd1);
      chk("R11 vector held", {16'b0, vec}, 32'h0FFF0);
      do_ack("R11");
      @(posedge clk); @(negedge clk);
      chk("R11 next grant", {16'b0, vec}, 32'h0FFFC);
      do_ack("R11 next");
      clear_inputs();
      @(posedge clk);

      // Constrained random
      for (int it = 0; it < 400; it++) begin
         logic [7:0] hsel;
         if ($urandom_range(3) == 0) begin
            hsel = ($urandom_range(1) == 0) ? 8'(8'hF0 - 8'(2 * $urandom_range(NP - 1)))
                                             : 8'($urandom);
            reg_write(1'b0, hsel);
         end
         if ($urandom_range(1) == 0) ccr_write(1'($urandom), 1'($urandom_range(3) == 0));
         run_case("R2 R3 R4 R7 random",
                  $urandom_range(15) == 0, $urandom_range(15) == 0,
                  $urandom_range(15) == 0, $urandom_range(15) == 0,
                  1'($urandom), 1'($urandom), NP'($urandom));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule